// File: doc/BRIEF.md
# Keyboard Wake-Key Power-Button Decoder

This block sits after a keyboard serial receiver and watches the stream of received scan-code bytes for one programmed key. When the key's make sequence arrives it gives a one-cycle wake pulse and raises a power-button status output. The status stays high until a selectable release rule fires: a hold timer counted in slow-clock ticks, the arrival of some other key, the programmed key's break sequence, or nothing short of a reset.

The programmed key is held in a small register port: two make bytes, three break bytes and a control byte. The control byte picks one of four scan-code formats, which sets how many of the programmed bytes form the make and break sequences, and the release rule. A lock bit in the control byte freezes all six registers until the next reset. Two resets exist: `rst_bat` restores every register, and `rst` clears only the lock bit and the decoder state.

Top module: `kbwake_decoder`

## Requirements
- R1: Register addresses 0 to 4 hold make byte 1, make byte 2, break byte 1, break byte 2 and break byte 3, each reset to 00h by `rst_bat`; address 5 holds the control byte, reset to 6Ch by `rst_bat`, with format in bits [3:2], release rule in bits [5:4] and lock in bit 7; every register reads back on `reg_rdata`.
- R2: While control bit 7 is 1, writes to all six registers are ignored; the lock cannot be cleared by a write, and `rst` clears only bit 7, keeping the other control bits.
- R3: Format 00 and 10 use a one-byte make (make byte 1), formats 01 and 11 a two-byte make (make bytes 1, 2); the break uses one byte in format 00, two in 01 and 10, and three in 11, compared in register order.
- R4: On the clock edge that samples the final make byte, `pme_pulse` is high for one cycle and `pwrbtn_sts` rises; a make match while the status is already high pulses again but does not restart the hold timer.
- R5: A byte that breaks a partial match abandons it, and that same byte is tested as the first byte of a new sequence.
- R6: In formats 10 and 11, a byte that directly follows an F0h byte never advances or completes the make sequence.
- R7: Release rule 00 drops the status on the HOLD_TICKS-th `tick` after it rose.
- R8: Release rule 01 drops the status on any byte other than E0h or F0h that does not complete the make sequence.
- R9: Release rule 10 drops the status when the break sequence completes.
- R10: Release rule 11 keeps the status high until a reset.
- R11: `rst` or `rst_bat` clears the status, the wake pulse and any partial match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset: clears lock and decoder state |
| rst_bat | input | 1 | Synchronous full reset of registers and decoder |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 to 5) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sc_valid | input | 1 | A scan-code byte is present this cycle |
| sc_code | input | 8 | Received scan-code byte |
| tick | input | 1 | Slow-clock enable for the hold timer |
| pme_pulse | output | 1 | One-cycle wake pulse per make match |
| pwrbtn_sts | output | 1 | Power-button status |

## Verification
The hardest case is a partial match that fails on a byte which is itself a valid start, such as a repeated E0h in a two-byte format, together with the set-2 break whose last byte equals the make byte. The stimulus reaches both by streaming E0h E0h 37h and F0h 37h through the scan-code port and checking that only the first pattern wakes. The hold timer's no-restart rule is reached by sending a second make between ticks and counting the ticks to the release.

// File: rtl/kbw_pkg.sv
`timescale 1ns/1ps
package kbw_pkg;

    localparam logic [7:0] SC_EXT   = 8'hE0;
    localparam logic [7:0] SC_REL   = 8'hF0;
    localparam logic [7:0] CTRL_RST = 8'h6C;

    localparam int MK_MAX    = 2;
    localparam int BK_MAX    = 3;
    localparam int NUM_BYTES = MK_MAX + BK_MAX;
    localparam int AW        = 3;
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NUM_BYTES);

    typedef enum logic [1:0] {
        FMT_S1_ONE = 2'b00,
        FMT_S1_EXT = 2'b01,
        FMT_S2_ONE = 2'b10,
        FMT_S2_EXT = 2'b11
    } kbw_fmt_e;

    typedef enum logic [1:0] {
        REL_TIMER = 2'b00,
        REL_OTHER = 2'b01,
        REL_BREAK = 2'b10,
        REL_HOLD  = 2'b11
    } kbw_rel_e;

    typedef struct packed {
        logic       lock;
        logic       rsv_hi;
        kbw_rel_e   rel;
        kbw_fmt_e   fmt;
        logic [1:0] rsv_lo;
    } kbw_ctrl_t;

    typedef struct packed {
        logic [MK_MAX-1:0][7:0] mk;
        logic [BK_MAX-1:0][7:0] bk;
        kbw_ctrl_t              ctrl;
    } kbw_cfg_t;

    function automatic logic [1:0] make_len(input logic [1:0] fmt);
        return fmt[0] ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] break_len(input logic [1:0] fmt);
        case (fmt)
            2'b00:   return 2'd1;
            2'b11:   return 2'd3;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/kbw_regs.sv
`timescale 1ns/1ps
module kbw_regs
    import kbw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_bat,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    output kbw_cfg_t      cfg
);

    logic [NUM_BYTES-1:0][7:0] byte_q;
    kbw_ctrl_t                 ctrl_q;
    logic                      wr_ok;

    assign wr_ok = wr && !ctrl_q.lock && !rst;

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst_bat) begin
                byte_q[i] <= '0;
            end else if (wr_ok && addr == AW'(i)) begin
                byte_q[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_bat) begin
            ctrl_q <= kbw_ctrl_t'(CTRL_RST);
        end else if (rst) begin
            ctrl_q.lock <= 1'b0;
        end else if (wr_ok && addr == CTRL_ADDR) begin
            ctrl_q <= kbw_ctrl_t'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata = ctrl_q;
        end else begin
            for (int i = 0; i < NUM_BYTES; i++) begin
                if (addr == AW'(i)) rdata = byte_q[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < MK_MAX; i++) cfg.mk[i] = byte_q[i];
        for (int i = 0; i < BK_MAX; i++) cfg.bk[i] = byte_q[MK_MAX + i];
        cfg.ctrl = ctrl_q;
    end

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst_bat)
        (ctrl_q.lock && !rst) |=> ($stable(byte_q) && $stable(ctrl_q))) // R2
        else $error("lock did not freeze registers");

endmodule

// File: rtl/kbw_seq_track.sv
`timescale 1ns/1ps
module kbw_seq_track #(
    parameter int MAXLEN = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              valid,
    input  logic [7:0]                        code,
    input  logic                              suppress,
    input  logic [$clog2(MAXLEN+1)-1:0]       len,
    input  logic [MAXLEN-1:0][7:0]            pat,
    output logic                              hit
);

    localparam int LW = $clog2(MAXLEN + 1);
    localparam int PW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

    logic [PW-1:0] pos_q, pos_d, cur;

    always_comb begin
        cur   = (LW'(pos_q) < len) ? pos_q : '0;
        pos_d = pos_q;
        hit   = 1'b0;
        if (valid) begin
            if (suppress) begin
                pos_d = '0;
            end else if (code == pat[cur]) begin
                if (LW'(cur) + LW'(1) == len) begin
                    hit   = 1'b1;
                    pos_d = '0;
                end else begin
                    pos_d = cur + PW'(1);
                end
            end else if (cur != '0 && code == pat[0]) begin
                if (len == LW'(1)) begin
                    hit   = 1'b1;
                    pos_d = '0;
                end else begin
                    pos_d = PW'(1);
                end
            end else begin
                pos_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end

    AST_SUPPRESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (valid && suppress) |=> (pos_q == '0 && !$past(hit))) // R6
        else $error("suppressed byte advanced a match");

endmodule

// File: rtl/kbw_release.sv
`timescale 1ns/1ps
module kbw_release
    import kbw_pkg::*;
#(
    parameter int HOLD_TICKS = 16384
) (
    input  logic     clk,
    input  logic     rst,
    input  kbw_rel_e mode,
    input  logic     make_hit,
    input  logic     break_hit,
    input  logic     other_hit,
    input  logic     tick,
    output logic     sts,
    output logic     pme
);

    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sts   <= 1'b0;
            pme   <= 1'b0;
            cnt_q <= '0;
        end else begin
            pme <= make_hit;
            if (make_hit) begin
                if (!sts) begin
                    sts   <= 1'b1;
                    cnt_q <= '0;
                end
            end else if (sts) begin
                case (mode)
                    REL_TIMER: if (tick) begin
                        if (cnt_q == LAST) sts <= 1'b0;
                        else               cnt_q <= cnt_q + CW'(1);
                    end
                    REL_OTHER: if (other_hit) sts <= 1'b0;
                    REL_BREAK: if (break_hit) sts <= 1'b0;
                    default:   sts <= 1'b1;
                endcase
            end
        end
    end

    AST_PME_WITH_STS: assert property (@(posedge clk) disable iff (rst)
        pme |-> sts) // R4
        else $error("wake pulse without status");

    AST_RISE_NEEDS_MAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(sts) |-> $past(make_hit)) // R4
        else $error("status rose without make");

    AST_TIMER_DROP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(sts) && $past(mode) == REL_TIMER) |-> $past(tick)) // R7
        else $error("timer release without tick");

    AST_HOLD_MODE: assert property (@(posedge clk) disable iff (rst)
        (sts && mode == REL_HOLD) |=> sts) // R10
        else $error("hold mode released status");

endmodule

// File: rtl/kbwake_decoder.sv
`timescale 1ns/1ps
module kbwake_decoder
    import kbw_pkg::*;
#(
    parameter int HOLD_TICKS = 16384
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rst_bat,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          sc_valid,
    input  logic [7:0]    sc_code,
    input  logic          tick,
    output logic          pme_pulse,
    output logic          pwrbtn_sts
);

    kbw_cfg_t   cfg;
    logic       clr;
    logic [1:0] fmt_bits;
    logic       prev_rel_q;
    logic       mk_sup;
    logic       make_hit, break_hit, other_hit;

    assign clr      = rst | rst_bat;
    assign fmt_bits = cfg.ctrl.fmt;

    kbw_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .rst_bat (rst_bat),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .cfg     (cfg)
    );

    always_ff @(posedge clk) begin
        if (clr)           prev_rel_q <= 1'b0;
        else if (sc_valid) prev_rel_q <= (sc_code == SC_REL);
    end

    assign mk_sup = fmt_bits[1] && prev_rel_q;

    kbw_seq_track #(.MAXLEN(MK_MAX)) u_make (
        .clk      (clk),
        .rst      (clr),
        .valid    (sc_valid),
        .code     (sc_code),
        .suppress (mk_sup),
        .len      (make_len(fmt_bits)),
        .pat      (cfg.mk),
        .hit      (make_hit)
    );

    kbw_seq_track #(.MAXLEN(BK_MAX)) u_break (
        .clk      (clk),
        .rst      (clr),
        .valid    (sc_valid),
        .code     (sc_code),
        .suppress (1'b0),
        .len      (break_len(fmt_bits)),
        .pat      (cfg.bk),
        .hit      (break_hit)
    );

    assign other_hit = sc_valid && sc_code != SC_EXT && sc_code != SC_REL && !make_hit;

    kbw_release #(.HOLD_TICKS(HOLD_TICKS)) u_rel (
        .clk       (clk),
        .rst       (clr),
        .mode      (cfg.ctrl.rel),
        .make_hit  (make_hit),
        .break_hit (break_hit),
        .other_hit (other_hit),
        .tick      (tick),
        .sts       (pwrbtn_sts),
        .pme       (pme_pulse)
    );

    AST_F0_BLOCKS_MAKE: assert property (@(posedge clk) disable iff (clr)
        (sc_valid && fmt_bits[1] && prev_rel_q) |-> !make_hit) // R6
        else $error("make matched after release prefix");

endmodule

// File: tb/kbwake_decoder_tb.sv
`timescale 1ns/1ps
module kbwake_decoder_tb;

    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rst_bat = 1'b1;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sc_valid = 1'b0;
    logic [7:0] sc_code = '0;
    logic       tick = 1'b0;
    logic       pme_pulse;
    logic       pwrbtn_sts;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    kbwake_decoder #(.HOLD_TICKS(HOLD)) u_dut (
        .clk(clk), .rst(rst), .rst_bat(rst_bat),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sc_valid(sc_valid), .sc_code(sc_code), .tick(tick),
        .pme_pulse(pme_pulse), .pwrbtn_sts(pwrbtn_sts)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic prog(input logic [7:0] m1, m2, b1, b2, b3, ctl);
        wr_reg(3'd0, m1); wr_reg(3'd1, m2);
        wr_reg(3'd2, b1); wr_reg(3'd3, b2); wr_reg(3'd4, b3);
        wr_reg(3'd5, ctl);
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        sc_valid = 1'b1; sc_code = b;
        @(negedge clk);
        sc_valid = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < 5; i++) begin
            rd_reg(3'(i), v);
            chk("R1 byte reset", v, 8'h00);
        end
        rd_reg(3'd5, v);
        chk("R1 ctrl reset", v, 8'h6C);
        chk("R11 sts reset", {7'd0, pwrbtn_sts}, 8'd0);
        chk("R11 pme reset", {7'd0, pme_pulse}, 8'd0);
    endtask

    task automatic t_fmt11_break();
        prog(8'hE0, 8'h37, 8'hE0, 8'hF0, 8'h37, 8'h6C);
        send(8'hE0);
        chk("R3 prefix only", {7'd0, pwrbtn_sts}, 8'd0);
        send(8'h37);
        chk("R4 pme on make", {7'd0, pme_pulse}, 8'd1);
        chk("R4 sts on make", {7'd0, pwrbtn_sts}, 8'd1);
        @(negedge clk);
        chk("R4 pme one cycle", {7'd0, pme_pulse}, 8'd0);
        send(8'hE0); send(8'hF0);
        chk("R9 partial break holds", {7'd0, pwrbtn_sts}, 8'd1);
        send(8'h37);
        chk("R9 break releases", {7'd0, pwrbtn_sts}, 8'd0);
        chk("R6 no make after F0", {7'd0, pme_pulse}, 8'd0);
    endtask

    task automatic t_abort();
        send(8'hE0); send(8'h12); send(8'h37);
        chk("R5 aborted prefix", {7'd0, pwrbtn_sts}, 8'd0);
        send(8'hE0); send(8'hE0); send(8'h37);
        chk("R5 re-evaluated start", {7'd0, pme_pulse}, 8'd1);
        send(8'hE0); send(8'hF0); send(8'h37);
        chk("R9 cleanup", {7'd0, pwrbtn_sts}, 8'd0);
    endtask

    task automatic t_other();
        prog(8'h37, 8'h00, 8'hB7, 8'h00, 8'h00, 8'h50);
        send(8'h37);
        chk("R3 single byte make", {7'd0, pwrbtn_sts}, 8'd1);
        send(8'hE0);
        chk("R8 prefix no release", {7'd0, pwrbtn_sts}, 8'd1);
        send(8'h37);
        chk("R4 repeat pme", {7'd0, pme_pulse}, 8'd1);
        chk("R8 make no release", {7'd0, pwrbtn_sts}, 8'd1);
        send(8'h1C);
        chk("R8 other releases", {7'd0, pwrbtn_sts}, 8'd0);
    endtask

    task automatic t_timer();
        prog(8'hE0, 8'h37, 8'hE0, 8'hB7, 8'h00, 8'h44);
        send(8'hE0); send(8'h37);
        chk("R3 set1 ext make", {7'd0, pwrbtn_sts}, 8'd1);
        pulse_tick(); pulse_tick();
        send(8'hE0); send(8'h37);
        chk("R4 second make pme", {7'd0, pme_pulse}, 8'd1);
        pulse_tick();
        chk("R7 held before last tick", {7'd0, pwrbtn_sts}, 8'd1);
        pulse_tick();
        chk("R7 timer release no restart", {7'd0, pwrbtn_sts}, 8'd0);
    endtask

    task automatic t_set2_one();
        prog(8'h37, 8'h00, 8'hF0, 8'h37, 8'h00, 8'h68);
        send(8'h37);
        chk("R3 set2 make", {7'd0, pwrbtn_sts}, 8'd1);
        send(8'hF0);
        chk("R9 F0 alone holds", {7'd0, pwrbtn_sts}, 8'd1);
        send(8'h37);
        chk("R9 set2 break releases", {7'd0, pwrbtn_sts}, 8'd0);
        chk("R6 break byte not make", {7'd0, pme_pulse}, 8'd0);
    endtask

    task automatic t_hold();
        logic [7:0] v;
        prog(8'h37, 8'h00, 8'hB7, 8'h00, 8'h00, 8'h70);
        send(8'h37);
        send(8'hB7); send(8'h1C);
        for (int i = 0; i < HOLD + 1; i++) pulse_tick();
        chk("R10 hold mode", {7'd0, pwrbtn_sts}, 8'd1);
        pulse_rst();
        chk("R11 rst clears sts", {7'd0, pwrbtn_sts}, 8'd0);
        rd_reg(3'd5, v);
        chk("R2 rst keeps ctrl", v, 8'h70);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        wr_reg(3'd5, 8'hEC);
        rd_reg(3'd5, v);
        chk("R2 lock set", v, 8'hEC);
        wr_reg(3'd0, 8'h55);
        rd_reg(3'd0, v);
        chk("R2 locked byte", v, 8'h37);
        wr_reg(3'd5, 8'h50);
        rd_reg(3'd5, v);
        chk("R2 locked ctrl", v, 8'hEC);
        pulse_rst();
        rd_reg(3'd5, v);
        chk("R2 rst clears lock only", v, 8'h6C);
        wr_reg(3'd0, 8'h55);
        rd_reg(3'd0, v);
        chk("R2 unlocked write", v, 8'h55);
        @(negedge clk); rst_bat = 1'b1;
        @(negedge clk); rst_bat = 1'b0;
        rd_reg(3'd0, v);
        chk("R1 bat reset byte", v, 8'h00);
        rd_reg(3'd5, v);
        chk("R1 bat reset ctrl", v, 8'h6C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; rst_bat = 1'b0;
        t_reset();
        t_fmt11_break();
        t_abort();
        t_other();
        t_timer();
        t_set2_one();
        t_hold();
        t_lock();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule